// File: doc/BRIEF.md
# Ethernet MAC Flow Control Unit

This block handles flow control for a 10/100 Ethernet MAC. The application raises a level-sensitive request when its receive buffers are close to full. In full-duplex mode the block turns the edges of that request into MAC control pause frames. It sends a frame carrying the configured quanta when the request rises. While the request is held, it repeats that frame whenever a programmable number of quanta ticks has passed. When the request falls, it sends a frame whose quanta field is zero, so the link partner can resume at once. In half-duplex mode no pause frames are sent. Instead a back-pressure output follows the request, and the transmit path uses it to force carrier or jam incoming traffic.

On the receive side the block watches the frame stream that the receiver delivers. It recognises pause frames addressed to either the reserved multicast address or the station's own address. Each recognised frame loads a pause timer. The timer counts down on an external tick that marks every 512 bit times, and transmission is held off while it is non-zero. A configuration bit decides whether a recognised pause frame is marked for dropping or left to reach the application.

The generated frame leaves on a valid/ready byte stream with no FCS; the CRC stage appends it. The block holds `tx_valid` until the transmit path takes the frame. While `tx_valid` is high and `tx_ready` is low, the data and last flag are held unchanged. The receive port only observes traffic, so it has no ready signal and the block can never stall the receiver.

Top module: `eth_flow_ctrl`

## Requirements
- R1: In full-duplex mode, a rising `fc_req` produces one 60-byte frame on the transmit stream. Its byte order is: bytes 0-5 are 01-80-C2-00-00-01; bytes 6-11 are `cfg_station_mac` with bits 47:40 sent first; bytes 12-13 are 0x88, 0x08; bytes 14-15 are 0x00, 0x01; bytes 16-17 are `cfg_pause_quanta`, high byte first; bytes 18-59 are zero. `tx_last` is high on byte 59 only.
- R2: In full-duplex mode, a falling `fc_req` produces one frame with the R1 layout whose bytes 16-17 are both zero.
- R3: While `fc_req` stays high in full-duplex mode, a further frame carrying `cfg_pause_quanta` is scheduled once `cfg_refresh_ticks` quanta ticks have been counted since the last frame was scheduled. No frame is sent before that count is reached. A value of 0 disables the refresh.
- R4: In half-duplex mode (`cfg_full_duplex`=0), no pause frame ever starts. `bp_active` follows `fc_req` one clock later.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values. A byte advances only on a clock edge where both are high.
- R6: A received frame counts as a pause frame only if all of these hold: the block is in full-duplex mode; bytes 0-5 equal 01-80-C2-00-00-01 or `cfg_station_mac`; bytes 12-13 are 0x88, 0x08; bytes 14-15 are 0x00, 0x01; the frame has at least 18 bytes; `rx_good` is high with `rx_last`. Recognition pulses `rx_pause_evt` for one cycle, in the clock after the last byte.
- R7: A recognised pause frame loads the pause timer from bytes 16-17 (high byte first). `tx_pause` is high while the timer is non-zero. Each `quanta_tick` pulse lowers the timer by one. A frame carrying zero quanta clears `tx_pause` at once.
- R8: `rx_pause_drop` pulses together with `rx_pause_evt` when `cfg_fwd_pause` is 0. It stays low when `cfg_fwd_pause` is 1.
- R9: After reset, `tx_valid`, `tx_pause`, `bp_active`, `rx_pause_evt` and `rx_pause_drop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_full_duplex | input | 1 | 1 = full duplex (pause frames), 0 = half duplex (back-pressure) |
| cfg_fwd_pause | input | 1 | 1 = leave received pause frames for the application |
| cfg_station_mac | input | 48 | Station address, used as source and as the accepted unicast destination |
| cfg_pause_quanta | input | 16 | Quanta advertised while the request is held |
| cfg_refresh_ticks | input | 16 | Quanta ticks between refresh frames (0 = no refresh) |
| fc_req | input | 1 | Flow-control request from the application, level sensitive |
| quanta_tick | input | 1 | One-cycle pulse every 512 bit times |
| tx_valid | output | 1 | Pause frame byte is valid |
| tx_ready | input | 1 | Transmit path accepts the byte |
| tx_data | output | 8 | Pause frame byte |
| tx_last | output | 1 | Final byte of the pause frame |
| rx_valid | input | 1 | Received byte is valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_good | input | 1 | Frame passed its FCS check, sampled with `rx_last` |
| rx_pause_evt | output | 1 | Pulse: a pause frame was recognised |
| rx_pause_drop | output | 1 | Pulse: the recognised pause frame should be dropped |
| tx_pause | output | 1 | Transmission is inhibited by the pause timer |
| bp_active | output | 1 | Half-duplex back-pressure request |

## Verification
On every cycle the assertions check that the transmit stream holds steady under a stall, that no pause frame starts outside full-duplex mode, and that a falling request in full duplex leaves a zero-quanta frame pending. They also check that the timer takes the received quanta exactly and changes only on a load or a tick, and that a pause event only follows a good final byte. The scenarios are needed to show the rest: the exact byte content of each generated frame; which address, type, opcode, length and FCS combinations are accepted; the refresh spacing measured in ticks; and the choice between dropping and forwarding.

// File: rtl/efc_pkg.sv
package efc_pkg;
  localparam logic [47:0] PAUSE_DA    = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OP    = 16'h0001;
  localparam int          HDR_BYTES   = 18;
  localparam int          MIN_PAYLOAD = 60;
endpackage

// File: rtl/efc_req_ctrl.sv
module efc_req_ctrl #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fd,
  input  logic          fc_req,
  input  logic          tick,
  input  logic [QW-1:0] cfg_quanta,
  input  logic [QW-1:0] cfg_refresh,
  input  logic          ack,
  output logic          pend,
  output logic [QW-1:0] pend_quanta,
  output logic          bp
);
  logic          req_q;
  logic [QW-1:0] rcnt;
  logic          rise, fall, refresh_hit;

  assign rise        = fc_req && !req_q;
  assign fall        = !fc_req && req_q;
  assign refresh_hit = fc_req && tick && (cfg_refresh != '0) && ((rcnt + 1'b1) >= cfg_refresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      rcnt        <= '0;
      pend        <= 1'b0;
      pend_quanta <= '0;
      bp          <= 1'b0;
    end else begin
      req_q <= fc_req;
      bp    <= !fd && fc_req;
      if (!fd) begin
        pend <= 1'b0;
        rcnt <= '0;
      end else if (rise) begin
        pend        <= 1'b1;
        pend_quanta <= cfg_quanta;
        rcnt        <= '0;
      end else if (fall) begin
        pend        <= 1'b1;
        pend_quanta <= '0;
        rcnt        <= '0;
      end else if (refresh_hit) begin
        pend        <= 1'b1;
        pend_quanta <= cfg_quanta;
        rcnt        <= '0;
      end else begin
        if (fc_req && tick) rcnt <= rcnt + 1'b1;
        if (ack) pend <= 1'b0;
      end
    end
  end

  // R2
  zero_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fd && req_q && !fc_req) |=> (pend && pend_quanta == '0));
endmodule

// File: rtl/efc_pause_gen.sv
module efc_pause_gen
  import efc_pkg::*;
#(
  parameter int QW          = 16,
  parameter int FRAME_BYTES = MIN_PAYLOAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fd,
  input  logic          start_req,
  input  logic [QW-1:0] start_quanta,
  input  logic [47:0]   station_mac,
  output logic          ack,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  localparam int IW = $clog2(FRAME_BYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BYTES - 1);

  logic          busy;
  logic [IW-1:0] idx;
  logic [15:0]   q_r;
  logic          beat;

  assign ack      = !busy && start_req && fd;
  assign tx_valid = busy;
  assign beat     = busy && tx_ready;
  assign tx_last  = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      q_r  <= '0;
    end else if (ack) begin
      busy <= 1'b1;
      idx  <= '0;
      q_r  <= 16'(start_quanta);
    end else if (beat) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    tx_data = 8'h00;
    if (idx < IW'(6))
      tx_data = PAUSE_DA[8'(47 - 8*int'(idx)) -: 8];
    else if (idx < IW'(12))
      tx_data = station_mac[8'(47 - 8*(int'(idx) - 6)) -: 8];
    else begin
      case (int'(idx))
        12: tx_data = CTRL_ETYPE[15:8];
        13: tx_data = CTRL_ETYPE[7:0];
        14: tx_data = PAUSE_OP[15:8];
        15: tx_data = PAUSE_OP[7:0];
        16: tx_data = q_r[15:8];
        17: tx_data = q_r[7:0];
        default: tx_data = 8'h00;
      endcase
    end
  end

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

// File: rtl/efc_rx_pause.sv
module efc_rx_pause
  import efc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fd,
  input  logic [47:0] station_mac,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_good,
  output logic        hit,
  output logic [15:0] hit_quanta
);
  logic [4:0] cnt;
  logic       mc_ok, uc_ok, type_ok, op_ok;
  logic [7:0] q_hi, q_lo;
  logic       mc_n, uc_n, type_n, op_n;
  int         ci;

  assign ci = int'(cnt);

  always_comb begin
    mc_n   = mc_ok;
    uc_n   = uc_ok;
    type_n = type_ok;
    op_n   = op_ok;
    if (ci < 6) begin
      if (rx_data != PAUSE_DA[8'(47 - 8*ci) -: 8])    mc_n = 1'b0;
      if (rx_data != station_mac[8'(47 - 8*ci) -: 8]) uc_n = 1'b0;
    end
    if (ci == 12 && rx_data != CTRL_ETYPE[15:8]) type_n = 1'b0;
    if (ci == 13 && rx_data != CTRL_ETYPE[7:0])  type_n = 1'b0;
    if (ci == 14 && rx_data != PAUSE_OP[15:8])   op_n = 1'b0;
    if (ci == 15 && rx_data != PAUSE_OP[7:0])    op_n = 1'b0;
  end

  assign hit = fd && rx_valid && rx_last && rx_good && (ci >= HDR_BYTES - 1)
               && (mc_n || uc_n) && type_n && op_n;
  assign hit_quanta = (ci == HDR_BYTES - 1) ? {q_hi, rx_data} : {q_hi, q_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      mc_ok   <= 1'b1;
      uc_ok   <= 1'b1;
      type_ok <= 1'b1;
      op_ok   <= 1'b1;
      q_hi    <= '0;
      q_lo    <= '0;
    end else if (rx_valid) begin
      if (rx_last) begin
        cnt     <= '0;
        mc_ok   <= 1'b1;
        uc_ok   <= 1'b1;
        type_ok <= 1'b1;
        op_ok   <= 1'b1;
      end else begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        mc_ok   <= mc_n;
        uc_ok   <= uc_n;
        type_ok <= type_n;
        op_ok   <= op_n;
        if (ci == 16) q_hi <= rx_data;
        if (ci == 17) q_lo <= rx_data;
      end
    end
  end
endmodule

// File: rtl/efc_pause_timer.sv
module efc_pause_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          tick,
  output logic          active
);
  logic [QW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (load)                 count <= load_val;
    else if (tick && count != '0)  count <= count - 1'b1;
  end

  assign active = (count != '0);

  // R7
  load_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count));
endmodule

// File: rtl/eth_flow_ctrl.sv
module eth_flow_ctrl
  import efc_pkg::*;
#(
  parameter int QW          = 16,
  parameter int FRAME_BYTES = MIN_PAYLOAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_full_duplex,
  input  logic          cfg_fwd_pause,
  input  logic [47:0]   cfg_station_mac,
  input  logic [QW-1:0] cfg_pause_quanta,
  input  logic [QW-1:0] cfg_refresh_ticks,
  input  logic          fc_req,
  input  logic          quanta_tick,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_good,
  output logic          rx_pause_evt,
  output logic          rx_pause_drop,
  output logic          tx_pause,
  output logic          bp_active
);
  logic          pend, ack, hit;
  logic [QW-1:0] pend_quanta;
  logic [15:0]   hit_quanta;

  efc_req_ctrl #(.QW(QW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fd(cfg_full_duplex), .fc_req(fc_req),
    .tick(quanta_tick), .cfg_quanta(cfg_pause_quanta), .cfg_refresh(cfg_refresh_ticks),
    .ack(ack), .pend(pend), .pend_quanta(pend_quanta), .bp(bp_active)
  );

  efc_pause_gen #(.QW(QW), .FRAME_BYTES(FRAME_BYTES)) u_gen (
    .clk(clk), .rst_n(rst_n), .fd(cfg_full_duplex), .start_req(pend),
    .start_quanta(pend_quanta), .station_mac(cfg_station_mac), .ack(ack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  efc_rx_pause u_rx (
    .clk(clk), .rst_n(rst_n), .fd(cfg_full_duplex), .station_mac(cfg_station_mac),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_good(rx_good),
    .hit(hit), .hit_quanta(hit_quanta)
  );

  efc_pause_timer #(.QW(QW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(hit), .load_val(QW'(hit_quanta)),
    .tick(quanta_tick), .active(tx_pause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pause_evt  <= 1'b0;
      rx_pause_drop <= 1'b0;
    end else begin
      rx_pause_evt  <= hit;
      rx_pause_drop <= hit && !cfg_fwd_pause;
    end
  end

  // R4
  fd_only_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(cfg_full_duplex));
  // R6
  evt_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_evt |-> $past(rx_valid && rx_last && rx_good));
endmodule

// File: tb/tb_eth_flow_ctrl.sv
module tb_eth_flow_ctrl;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] RES = 48'h0180C2000001;
  localparam logic [47:0] OTH = 48'h021122334455;
  localparam logic [15:0] CFGQ = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_full_duplex = 1'b1, cfg_fwd_pause = 1'b0;
  logic [15:0] cfg_pause_quanta = CFGQ, cfg_refresh_ticks = 16'd2;
  logic fc_req = 1'b0, quanta_tick = 1'b0, tx_ready = 1'b1;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_good = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, tx_last, rx_pause_evt, rx_pause_drop, tx_pause, bp_active;
  logic [7:0] tx_data;
  int checks = 0, errors = 0;
  logic exp_pause = 1'b0;

  always #10 clk = ~clk;

  eth_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_full_duplex(cfg_full_duplex), .cfg_fwd_pause(cfg_fwd_pause),
    .cfg_station_mac(STA), .cfg_pause_quanta(cfg_pause_quanta), .cfg_refresh_ticks(cfg_refresh_ticks),
    .fc_req(fc_req), .quanta_tick(quanta_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_good(rx_good), .rx_pause_evt(rx_pause_evt),
    .rx_pause_drop(rx_pause_drop), .tx_pause(tx_pause), .bp_active(bp_active)
  );

  // vector: {da_kind[1:0], bad_type, bad_op, bad_crc, fwd, short, exp_hit, exp_drop, 7'b0, quanta}
  localparam logic [31:0] RXV [0:7] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd0, 16'h0005},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'd0, 16'h0003},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 16'h0000},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 16'h0000},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 16'h0000},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 16'h0000},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0, 16'h0000},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd0, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(input int b, input logic [15:0] q);
    if (b < 6)  return RES[47 - 8*b -: 8];
    if (b < 12) return STA[47 - 8*(b-6) -: 8];
    case (b)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h00;
      15: return 8'h01;
      16: return q[15:8];
      17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rx_byte(input int b, input logic [1:0] kind,
                                         input logic bt, input logic bo, input logic [15:0] q);
    logic [47:0] da;
    da = (kind == 2'd0) ? RES : (kind == 2'd1) ? STA : OTH;
    if (b < 6)  return da[47 - 8*b -: 8];
    if (b < 12) return 8'(8'hA0 + b);
    case (b)
      12: return 8'h88;
      13: return bt ? 8'h00 : 8'h08;
      14: return 8'h00;
      15: return bo ? 8'h02 : 8'h01;
      16: return q[15:8];
      17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic send_rx(input logic [1:0] kind, input logic bt, input logic bo,
                         input logic bc, input logic sh, input logic [15:0] q);
    int n;
    n = sh ? 16 : 60;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = rx_byte(b, kind, bt, bo, q);
      rx_last  = (b == n-1);
      rx_good  = (b == n-1) && !bc;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_good = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); quanta_tick = 1'b1;
    @(negedge clk); quanta_tick = 1'b0;
  endtask

  task automatic collect(input string req, input logic [15:0] q, input int stall_at);
    int w;
    w = 0;
    while (!tx_valid && w < 40) begin @(negedge clk); w++; end
    check(req, {31'd0, tx_valid}, 32'd1);
    if (!tx_valid) return;
    for (int b = 0; b < 60; b++) begin
      check(req, {24'd0, tx_data}, {24'd0, gen_byte(b, q)});
      check(req, {31'd0, tx_last}, {31'd0, (b == 59)});
      if (b == stall_at) begin
        tx_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check("R5", {22'd0, tx_valid, tx_last, tx_data}, {22'd0, 1'b1, 1'b0, gen_byte(b, q)});
        end
        tx_ready = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {27'd0, tx_valid, tx_pause, bp_active, rx_pause_evt, rx_pause_drop}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {27'd0, tx_valid, tx_pause, bp_active, rx_pause_evt, rx_pause_drop}, 32'd0);

    // R6 R7 R8: receive vector table
    for (int v = 0; v < 8; v++) begin
      logic [31:0] e;
      e = RXV[v];
      cfg_fwd_pause = e[26];
      send_rx(e[31:30], e[29], e[28], e[27], e[25], e[15:0]);
      if (e[24]) exp_pause = (e[15:0] != 16'd0);
      check("R6", {31'd0, rx_pause_evt}, {31'd0, e[24]});
      check("R8", {31'd0, rx_pause_drop}, {31'd0, e[23]});
      check("R7", {31'd0, tx_pause}, {31'd0, exp_pause});
    end
    cfg_fwd_pause = 1'b0;

    // R7: countdown on ticks
    send_rx(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd3);
    check("R7", {31'd0, tx_pause}, 32'd1);
    pulse_tick(); pulse_tick();
    check("R7", {31'd0, tx_pause}, 32'd1);
    pulse_tick();
    check("R7", {31'd0, tx_pause}, 32'd0);

    // R1: request rises in full duplex
    fc_req = 1'b1;
    collect("R1", CFGQ, -1);
    // R3: no refresh before the tick count is reached
    pulse_tick();
    repeat (30) @(negedge clk);
    check("R3", {31'd0, tx_valid}, 32'd0);
    pulse_tick();
    collect("R3", CFGQ, -1);

    // R2 + R5: release gives zero quanta, with a stall mid-frame
    fc_req = 1'b0;
    collect("R2", 16'd0, 5);
    repeat (20) @(negedge clk);
    check("R2", {31'd0, tx_valid}, 32'd0);

    // R4: half duplex uses back-pressure only
    cfg_full_duplex = 1'b0;
    @(negedge clk);
    fc_req = 1'b1;
    @(negedge clk);
    check("R4", {31'd0, bp_active}, 32'd1);
    pulse_tick(); pulse_tick(); pulse_tick();
    repeat (40) @(negedge clk);
    check("R4", {31'd0, tx_valid}, 32'd0);
    fc_req = 1'b0;
    @(negedge clk);
    check("R4", {31'd0, bp_active}, 32'd0);
    repeat (40) @(negedge clk);
    check("R4", {31'd0, tx_valid}, 32'd0);
    // R6: pause frames are not recognised in half duplex
    send_rx(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5);
    check("R6", {30'd0, rx_pause_evt, tx_pause}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule